// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block translates 32-bit effective addresses to physical addresses through a fully associative table of entries that software fills. Each entry holds its own page size, picked from eight sizes between 1 KB and 16 MB. Each entry also holds an 8-bit tag that names the process owning it. Software loads an entry by presenting an index, a high word, a low word and an owner tag on the write port for one cycle.

A lookup presents an address, the current process number, and a flag that says whether the access is an instruction fetch or a data access. Two enable inputs switch translation on or off separately for the instruction side and the data side. One cycle later the block returns either a hit with the physical address, or a fault on the side that made the access. When translation is off for the accessing side, the address passes through unchanged and always hits.

Top module: `vpage_tlb`

## Requirements
- R1: While reset is asserted, and in the response to a translated lookup issued after reset with no entries written, no entry hits. During reset all response outputs are zero.
- R2: A write presented in a cycle is not seen by a lookup presented in that same cycle. It is seen by every lookup from the next cycle onward.
- R3: An entry takes part in a lookup only when two conditions hold: bit 6 of its high word (the valid bit) is 1, and its owner tag equals `cur_pid`.
- R4: Bits 9:7 of the high word form a size code s from 0 to 7. The page mask for code s is all ones shifted left by 10+2*s bits. Code 0 gives a 1 KB page and code 7 gives a 16 MB page.
- R5: A taking-part entry hits when (address AND mask) equals (high word AND mask).
- R6: On a hit, the physical address is (low word AND mask) OR (address AND NOT mask).
- R7: For an instruction lookup (`lk_is_data`=0) translation follows `xlat_inst_en`. For a data lookup it follows `xlat_data_en`. When the selected enable is 0, the response hits and the physical address equals the effective address.
- R8: When several entries hit, the entry with the lowest index supplies the physical address.
- R9: A translated lookup with no hitting entry returns `rsp_hit`=0 and a fault. The fault is `inst_fault` when `lk_is_data`=0 and `data_fault` when `lk_is_data`=1.
- R10: The response to a lookup presented at a clock edge appears on the outputs right after that edge. `rsp_valid` is 1 for exactly those responses.
- R11: In a cycle after one with `lk_valid`=0, `rsp_valid`, `rsp_hit`, both faults and `rsp_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 6 | Index of the entry to write |
| wr_hi | input | 32 | Entry high word: page number, size code in bits 9:7, valid in bit 6 |
| wr_lo | input | 32 | Entry low word: physical page base |
| wr_tid | input | 8 | Owner tag of the entry |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Effective address |
| lk_is_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| cur_pid | input | 8 | Current process number |
| xlat_inst_en | input | 1 | Translation enable for instruction fetches |
| xlat_data_en | input | 1 | Translation enable for data accesses |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found, or translation disabled |
| rsp_paddr | output | 32 | Physical address |
| inst_fault | output | 1 | Instruction-side miss |
| data_fault | output | 1 | Data-side miss |

## Verification
Some properties are checked on every cycle. At most one of hit and the two faults is set. A response appears only after a lookup. A data fault only ever answers a data access. A hit always keeps the low ten address bits. A lookup with translation off returns its own address.

Other behaviour can only be shown by the bench scenarios, because the stored entries decide it. These are the masking for each size code, owner-tag filtering, lowest-index priority among overlapping pages, and when a write becomes visible. The bench checks them against a reference table and lookup function of its own, using both random and directed entries.

// File: rtl/vpage_tlb.sv
module vpage_tlb #(
  parameter int ENTRIES       = 64,
  parameter int TID_W         = 8,
  parameter int AW            = 32,
  parameter int MIN_PAGE_BITS = 10,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_hi,
  input  logic [AW-1:0]    wr_lo,
  input  logic [TID_W-1:0] wr_tid,
  input  logic             lk_valid,
  input  logic [AW-1:0]    lk_addr,
  input  logic             lk_is_data,
  input  logic [TID_W-1:0] cur_pid,
  input  logic             xlat_inst_en,
  input  logic             xlat_data_en,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [AW-1:0]    rsp_paddr,
  output logic             inst_fault,
  output logic             data_fault
);
  localparam int VBIT = 6;
  localparam int SZ_LO = 7;

  function automatic logic [AW-1:0] page_mask(input logic [2:0] s);
    logic [AW-1:0] ones;
    ones = '1;
    return ones << (5'(MIN_PAGE_BITS) + {1'b0, s, 1'b0});
  endfunction

  logic [AW-1:0]    e_hi  [ENTRIES];
  logic [AW-1:0]    e_lo  [ENTRIES];
  logic [TID_W-1:0] e_tid [ENTRIES];
  logic [ENTRIES-1:0] e_v;

  always_ff @(posedge clk) begin
    if (!rst_n) e_v <= '0;
    else if (wr_en) e_v[wr_idx] <= wr_hi[VBIT];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_hi[wr_idx]  <= wr_hi;
      e_lo[wr_idx]  <= wr_lo;
      e_tid[wr_idx] <= wr_tid;
    end
  end

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [AW-1:0] m;
    assign m = page_mask(e_hi[g][SZ_LO+2:SZ_LO]);
    assign match[g] = e_v[g] && (e_tid[g] == cur_pid) && (((lk_addr ^ e_hi[g]) & m) == '0);
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  logic [AW-1:0] sel_mask, xl_paddr;
  logic xlat_on, any_hit;
  assign sel_mask = page_mask(e_hi[sel][SZ_LO+2:SZ_LO]);
  assign xl_paddr = (e_lo[sel] & sel_mask) | (lk_addr & ~sel_mask);
  assign xlat_on  = lk_is_data ? xlat_data_en : xlat_inst_en;
  assign any_hit  = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_paddr  <= '0;
      inst_fault <= 1'b0;
      data_fault <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && (!xlat_on || any_hit);
      rsp_paddr  <= !lk_valid ? '0 : (!xlat_on ? lk_addr : (any_hit ? xl_paddr : '0));
      inst_fault <= lk_valid && xlat_on && !any_hit && !lk_is_data;
      data_fault <= lk_valid && xlat_on && !any_hit && lk_is_data;
    end
  end

  // R9
  excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, inst_fault, data_fault}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit || inst_fault || data_fault || rsp_valid) |-> $past(lk_valid));

  // R9
  dfault_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_fault |-> $past(lk_is_data));

  // R6
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_paddr[MIN_PAGE_BITS-1:0] == $past(lk_addr[MIN_PAGE_BITS-1:0])));

  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_valid && !(lk_is_data ? xlat_data_en : xlat_inst_en))
      |-> (rsp_hit && rsp_paddr == $past(lk_addr)));
endmodule

// File: tb/tb_vpage_tlb.sv
module tb_vpage_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_idx = '0;
  logic [31:0] wr_hi = '0, wr_lo = '0;
  logic [7:0] wr_tid = '0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_is_data = 1'b0;
  logic [7:0] cur_pid = '0;
  logic xlat_inst_en = 1'b1, xlat_data_en = 1'b1;
  logic rsp_valid, rsp_hit, inst_fault, data_fault;
  logic [31:0] rsp_paddr;

  always #10 clk = ~clk;

  vpage_tlb dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_hi [64];
  logic [31:0] m_lo [64];
  logic [7:0]  m_tid [64];

  function automatic logic [31:0] mask_of(input logic [2:0] s);
    return 32'hFFFF_FFFF << (10 + 2 * int'(s));
  endfunction

  function automatic logic [31:0] mkhi(input logic [31:0] pg, input logic [2:0] s, input bit v);
    return (pg & 32'hFFFF_FC00) | (32'(s) << 7) | (32'(v) << 6);
  endfunction

  task automatic model(input logic [31:0] a, input bit d, input logic [7:0] pid,
                       input bit ie, input bit de, output bit hit, output logic [31:0] pa);
    logic [31:0] m;
    hit = 0; pa = '0;
    if (!(d ? de : ie)) begin hit = 1; pa = a; return; end
    for (int i = 0; i < 64; i++) begin
      m = mask_of(m_hi[i][9:7]);
      if (!hit && m_hi[i][6] && m_tid[i] == pid && ((a & m) == (m_hi[i] & m))) begin
        hit = 1; pa = (m_lo[i] & m) | (a & ~m);
      end
    end
  endtask

  task automatic compare(input string req, input bit eh, input logic [31:0] ep, input bit d);
    bit eif, edf;
    eif = !eh && !d; edf = !eh && d;
    n_cmp++;
    if (rsp_valid !== 1'b1 || rsp_hit !== eh || inst_fault !== eif || data_fault !== edf ||
        (eh && rsp_paddr !== ep)) begin
      n_bad++;
      $display("FAIL %s: got v=%b h=%b pa=%h if=%b df=%b, exp h=%b pa=%h if=%b df=%b",
               req, rsp_valid, rsp_hit, rsp_paddr, inst_fault, data_fault, eh, ep, eif, edf);
    end
  endtask

  task automatic do_write(input int idx, input logic [31:0] hi, input logic [31:0] lo, input logic [7:0] tid);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_hi = hi; wr_lo = lo; wr_tid = tid;
    @(posedge clk); #1;
    wr_en = 0;
    m_hi[idx] = hi; m_lo[idx] = lo; m_tid[idx] = tid;
  endtask

  task automatic do_look(input string req, input logic [31:0] a, input bit d, input logic [7:0] pid);
    bit eh; logic [31:0] ep;
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_is_data = d; cur_pid = pid;
    model(a, d, pid, xlat_inst_en, xlat_data_en, eh, ep);
    @(posedge clk); #1;
    lk_valid = 0;
    compare(req, eh, ep, d);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit eh; logic [31:0] ep;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin m_hi[i] = '0; m_lo[i] = '0; m_tid[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held at zero during reset
    n_cmp++;
    if ({rsp_valid, rsp_hit, inst_fault, data_fault} !== 4'b0 || rsp_paddr !== '0) begin
      n_bad++; $display("FAIL R1: got outputs nonzero in reset, exp zero");
    end
    @(negedge clk); rst_n = 1;
    // R1 R9: empty table misses on each side
    do_look("R1 R9 inst miss", 32'h1234_5678, 0, 8'd0);
    do_look("R1 R9 data miss", 32'h0000_0000, 1, 8'd0);
    // R11: idle cycle quiet
    @(posedge clk); #1;
    n_cmp++;
    if ({rsp_valid, rsp_hit, inst_fault, data_fault} !== 4'b0 || rsp_paddr !== '0) begin
      n_bad++; $display("FAIL R11: got v=%b h=%b pa=%h, exp all zero", rsp_valid, rsp_hit, rsp_paddr);
    end
    // R8: overlapping pages, lowest index wins
    do_write(9, mkhi(32'h1234_5400, 3'd0, 1), 32'hB000_0000, 8'd1);
    do_write(5, mkhi(32'h1200_0000, 3'd7, 1), 32'hA000_0000, 8'd1);
    do_look("R8 R4 R6 priority", 32'h1234_5678, 1, 8'd1);
    // R3: invalidating entry 5 exposes entry 9
    do_write(5, mkhi(32'h1200_0000, 3'd7, 0), 32'hA000_0000, 8'd1);
    do_look("R3 R8 invalid skipped", 32'h1234_5678, 0, 8'd1);
    // R3: tag mismatch
    do_look("R3 tag mismatch", 32'h1234_5678, 0, 8'd2);
    // R5: address just past the 1 KB page misses
    do_look("R5 page edge", 32'h1234_5800, 1, 8'd1);
    // R2: write and lookup in same cycle see old content, next cycle sees new
    @(negedge clk);
    wr_en = 1; wr_idx = 6'd0; wr_hi = mkhi(32'h4000_0000, 3'd3, 1); wr_lo = 32'h8765_0000; wr_tid = 8'd7;
    lk_valid = 1; lk_addr = 32'h4000_1234; lk_is_data = 1; cur_pid = 8'd7;
    model(32'h4000_1234, 1, 8'd7, 1, 1, eh, ep);
    @(posedge clk); #1;
    wr_en = 0; lk_valid = 0;
    compare("R2 same-cycle old", eh, ep, 1);
    m_hi[0] = mkhi(32'h4000_0000, 3'd3, 1); m_lo[0] = 32'h8765_0000; m_tid[0] = 8'd7;
    do_look("R2 next-cycle new", 32'h4000_1234, 1, 8'd7);
    // R7: per-side enable
    xlat_data_en = 0;
    do_look("R7 data passthrough", 32'hDEAD_BEEF, 1, 8'd3);
    do_look("R7 inst still translated", 32'hDEAD_BEEF, 0, 8'd3);
    xlat_data_en = 1; xlat_inst_en = 0;
    do_look("R7 inst passthrough", 32'hCAFE_0001, 0, 8'd3);
    xlat_inst_en = 1;
    // R4: every size code
    for (int s = 0; s < 8; s++) begin
      do_write(20 + s, mkhi(32'h6000_0000 + 32'(s) * 32'h0200_0000, 3'(s), 1), 32'h0ABC_DEF0 ^ 32'(s << 28), 8'd9);
      do_look("R4 size code", 32'h6000_0000 + 32'(s) * 32'h0200_0000 + 32'h0015_5A5C, 1, 8'd9);
    end
    // R3 R5 R6 R8 R9 R10: random mix
    for (int k = 0; k < 64; k++)
      do_write(k, mkhi($urandom, 3'($urandom_range(0, 7)), ($urandom_range(0, 4) != 0)),
               $urandom, 8'($urandom_range(0, 3)));
    for (int n = 0; n < 600; n++) begin
      int j;
      logic [31:0] a;
      j = $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) a = $urandom;
      else a = (m_hi[j] & mask_of(m_hi[j][9:7])) | ($urandom & ~mask_of(m_hi[j][9:7]));
      xlat_inst_en = ($urandom_range(0, 9) != 0);
      xlat_data_en = ($urandom_range(0, 9) != 0);
      do_look("R5 R6 R9 R10 random", a, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 3)));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule